// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer, nine bits wide with a power-of-two depth. A write clock and a read clock run fully independently of each other. Each side moves a binary pointer and a Gray copy of it. The Gray copy crosses to the other clock through a two-flop synchroniser. Each side then registers its own flags from its own pointer and the synchronised pointer of the far side. Empty and almost-empty are active low and change only on read-clock edges. Full and almost-full are active low and change only on write-clock edges. The almost-empty threshold n and the almost-full threshold m arrive as quasi-static inputs from a neighbouring offset-register block, which holds 7 in both after reset.

A pin with two roles, `wen2_ld`, is sampled on write-clock edges while reset is held low. Its level selects the write mode through a small state machine in the write domain. The states are `WM_CFG` (in reset, or on the first write edge after release), `WM_TWO_EN` and `WM_LOAD`. The transition `WM_CFG -> WM_TWO_EN` is taken when the captured level was high. The transition `WM_CFG -> WM_LOAD` is taken when it was low. Both mode states hold until the next reset.

In `WM_TWO_EN` the pin is a second write enable. In `WM_LOAD` the pin acts as a load control. While it is low, a write strobe goes to the offset block through `ofs_wr` and the FIFO stores nothing. The read data register holds the last word read. The output enable is not a three-state driver here; it appears as the qualifier `q_valid`.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst_n` is low: `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1, `dout`=0, and the FIFO holds no words.
- R2: The level of `wen2_ld` at the write-clock edges during reset selects the mode: 1 gives two-enable mode and 0 gives load-control mode. The mode holds until the next reset. No write is accepted on the first write-clock edge after reset is released.
- R3: In two-enable mode, a word is stored on a write-clock edge only when `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. Setting `wen2_ld`=0 blocks the write.
- R4: In load-control mode, a word is stored when `wen1_n`=0, `wen2_ld`=1 and `full_n`=1. When `wen1_n`=0 and `wen2_ld`=0, nothing is stored and `ofs_wr` is 1. `ofs_wr` is 0 in two-enable mode.
- R5: A read happens on a read-clock edge when `ren1_n`=0, `ren2_n`=0 and `empty_n`=1. `dout` takes the oldest unread word on that edge, and words leave in the order they were written.
- R6: A write attempted while `full_n`=0 is ignored. The word is never read out.
- R7: A read attempted while `empty_n`=0 leaves `dout` and the read pointer unchanged.
- R8: `empty_n` is 0 exactly when the read side sees no unread words. It rises within a few read-clock edges of the first write, and that first word can be read on the following read-clock edge.
- R9: `full_n` is 0 when DEPTH words are unread, as seen from the write side.
- R10: `almost_empty_n` is 0 when the unread count is at most n (`ae_ofs`) and 1 when it is n+1 or more. It is registered in the read domain.
- R11: `almost_full_n` is 0 when the unread count is at least DEPTH−m (`af_ofs`) and 1 when it is lower. It is registered in the write domain.
- R12: `q_valid` equals the inverse of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable, or load control; role chosen at reset |
| din | input | DATA_W | Write data |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low |
| ae_ofs | input | AW | Almost-empty threshold n |
| af_ofs | input | AW | Almost-full threshold m |
| dout | output | DATA_W | Registered read data |
| q_valid | output | 1 | Output qualifier, high when `oe_n` is low |
| ofs_wr | output | 1 | Write strobe for the offset block (load-control mode) |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The bench fills the buffer to exactly DEPTH words, pushes one extra word and then drains it. A design without overflow protection would wrap its write pointer: it would lose the full state and return the extra word or corrupt data. The bench also reads past empty. An unguarded read pointer would move, or `dout` would change instead of holding the last word. Each threshold is probed one word below and at its boundary, so an off-by-one compare shows up as a flag one word early or late. Reset is applied with both levels of `wen2_ld`. This exposes a mode that is not latched, a load-low write that leaks into the memory, and a cleared `dout` that is missing after earlier traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic [1:0] {
        WM_CFG    = 2'd0,
        WM_TWO_EN = 2'd1,
        WM_LOAD   = 2'd2
    } wmode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [AW-1:0] af_ofs,
    input  logic [PW-1:0] r_gray_s,
    output logic          wr_fire,
    output logic [AW-1:0] w_addr,
    output logic [PW-1:0] w_gray,
    output logic          full_n,
    output logic          af_n,
    output logic          ofs_wr,
    output wmode_e        mode_q
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wmode_e        mode_d;
    logic          cfg_q;
    logic          want;
    logic [PW-1:0] w_bin, w_next, r_bin, cnt, af_lim;

    // level of the dual-role pin while reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) cfg_q <= wen2_ld;
    end

    // state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) mode_q <= WM_CFG;
        else        mode_q <= mode_d;
    end

    // next state and outputs
    always_comb begin
        mode_d = mode_q;
        want   = 1'b0;
        ofs_wr = 1'b0;
        unique case (mode_q)
            WM_CFG:    mode_d = cfg_q ? WM_TWO_EN : WM_LOAD;
            WM_TWO_EN: want = !wen1_n && wen2_ld;
            WM_LOAD: begin
                want   = !wen1_n && wen2_ld;
                ofs_wr = !wen1_n && !wen2_ld;
            end
            default:   mode_d = WM_CFG;
        endcase
    end

    assign wr_fire = want && full_n;
    assign w_next  = w_bin + PW'(wr_fire);
    assign r_bin   = g2b(r_gray_s);
    assign cnt     = w_next - r_bin;
    assign af_lim  = DEPTH_P - {1'b0, af_ofs};
    assign w_addr  = w_bin[AW-1:0];

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            w_bin  <= '0;
            w_gray <= '0;
            full_n <= 1'b1;
            af_n   <= 1'b1;
        end else begin
            w_bin  <= w_next;
            w_gray <= w_next ^ (w_next >> 1);
            full_n <= (cnt != DEPTH_P);
            af_n   <= (cnt < af_lim);
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [AW-1:0] ae_ofs,
    input  logic [PW-1:0] w_gray_s,
    output logic          rd_fire,
    output logic [AW-1:0] r_addr,
    output logic [PW-1:0] r_gray,
    output logic          empty_n,
    output logic          ae_n
);
    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] r_bin, r_next, w_bin, cnt;

    assign rd_fire = !ren1_n && !ren2_n && empty_n;
    assign r_next  = r_bin + PW'(rd_fire);
    assign w_bin   = g2b(w_gray_s);
    assign cnt     = w_bin - r_next;
    assign r_addr  = r_bin[AW-1:0];

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            r_bin   <= '0;
            r_gray  <= '0;
            empty_n <= 1'b0;
            ae_n    <= 1'b0;
        end else begin
            r_bin   <= r_next;
            r_gray  <= r_next ^ (r_next >> 1);
            empty_n <= (cnt != '0);
            ae_n    <= (cnt > {1'b0, ae_ofs});
        end
    end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    input  logic [DATA_W-1:0] din,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     ae_ofs,
    input  logic [AW-1:0]     af_ofs,
    output logic [DATA_W-1:0] dout,
    output logic              q_valid,
    output logic              ofs_wr,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_fire, rd_fire;
    logic [AW-1:0]     w_addr, r_addr;
    logic [PW-1:0]     w_gray, r_gray, w_gray_s, r_gray_s;
    wmode_e            w_mode;

    dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .af_ofs(af_ofs), .r_gray_s(r_gray_s), .wr_fire(wr_fire),
        .w_addr(w_addr), .w_gray(w_gray), .full_n(full_n),
        .af_n(almost_full_n), .ofs_wr(ofs_wr), .mode_q(w_mode)
    );

    dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .ae_ofs(ae_ofs), .w_gray_s(w_gray_s), .rd_fire(rd_fire),
        .r_addr(r_addr), .r_gray(r_gray), .empty_n(empty_n),
        .ae_n(almost_empty_n)
    );

    dcf_sync #(.WIDTH(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));
    dcf_sync #(.WIDTH(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));

    always_ff @(posedge wclk) begin
        if (wr_fire) mem[w_addr] <= din;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (rd_fire) dout <= mem[r_addr];
    end

    assign q_valid = !oe_n;
endmodule

// File: rtl/dcf_fifo_checker.sv
module dcf_fifo_checker
    import dcf_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              wen2_ld,
    input logic              full_n,
    input logic              empty_n,
    input logic              almost_full_n,
    input logic              almost_empty_n,
    input logic [DATA_W-1:0] dout,
    input logic [PW-1:0]     w_gray,
    input logic [PW-1:0]     r_gray,
    input wmode_e            w_mode
);
    assert_no_overflow_R6: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(w_gray));

    assert_no_underflow_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> ($stable(r_gray) && $stable(dout)));

    assert_full_inside_af_R11: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    assert_empty_inside_ae_R10: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R8: write pointer as seen by the read side moves one Gray bit at a time
    assert_gray_step_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    assert_mode_hold_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        (w_mode != WM_CFG) |=> $stable(w_mode));

    assert_load_low_no_store_R4: assert property (@(posedge wclk) disable iff (!rst_n)
        (w_mode == WM_LOAD && !wen2_ld) |=> $stable(w_gray));
endmodule

bind dcf_fifo dcf_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen2_ld(wen2_ld),
    .full_n(full_n), .empty_n(empty_n), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .dout(dout), .w_gray(w_gray),
    .r_gray(r_gray), .w_mode(w_mode)
);

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
    localparam int DW = 9;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam int NV = 10;
    // bit 9 set: read and expect bits 8:0; clear: write bits 8:0
    localparam logic [9:0] VEC [NV] = '{10'h1A5, 10'h0F3, 10'h03C, 10'h3A5, 10'h1FF,
                                        10'h2F3, 10'h23C, 10'h000, 10'h3FF, 10'h200};

    logic wclk = 0, rclk = 0, rst_n = 0;
    logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] ae_ofs = AW'(7), af_ofs = AW'(7);
    logic [DW-1:0] dout;
    logic q_valid, ofs_wr, empty_n, full_n, almost_empty_n, almost_full_n;
    int checks = 0, errors = 0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dcf_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .ae_ofs(ae_ofs),
        .af_ofs(af_ofs), .dout(dout), .q_valid(q_valid), .ofs_wr(ofs_wr),
        .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 0; wen2_ld = pin; wen1_n = 1; ren1_n = 1; ren2_n = 1;
        repeat (4) @(negedge wclk);
        check("R1 empty_n", 32'(empty_n), 0);
        check("R1 almost_empty_n", 32'(almost_empty_n), 0);
        check("R1 full_n", 32'(full_n), 1);
        check("R1 almost_full_n", 32'(almost_full_n), 1);
        check("R1 dout", 32'(dout), 0);
        rst_n = 1;
        repeat (3) @(negedge wclk);
        wen2_ld = 1;
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic pin);
        @(negedge wclk); din = d; wen1_n = 0; wen2_ld = pin;
        @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    endtask

    task automatic settle_r(); repeat (8) @(negedge rclk); endtask
    task automatic settle_w(); repeat (8) @(negedge wclk); endtask

    task automatic rd(input string tag, input logic [DW-1:0] exp);
        for (int k = 0; k < 20 && !empty_n; k++) @(negedge rclk);
        check({tag, " empty_n before read"}, 32'(empty_n), 1);
        @(negedge rclk); ren1_n = 0; ren2_n = 0;
        @(negedge rclk); ren1_n = 1; ren2_n = 1;
        check(tag, 32'(dout), 32'(exp));
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1);

        // R5: vector walk, interleaved writes and reads
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][9]) rd("R5 table read", VEC[i][8:0]);
            else           wr(VEC[i][8:0], 1'b1);
        end
        settle_r();
        check("R8 empty after table", 32'(empty_n), 0);

        // R10/R11 thresholds with n=3, m=2
        ae_ofs = AW'(3); af_ofs = AW'(2);
        for (int i = 0; i < 3; i++) wr(9'h040 + 9'(i), 1'b1);
        settle_r();
        check("R10 three words at n=3", 32'(almost_empty_n), 0);
        check("R8 nonempty", 32'(empty_n), 1);
        wr(9'h043, 1'b1);
        settle_r();
        check("R10 four words at n=3", 32'(almost_empty_n), 1);
        for (int i = 4; i < 13; i++) wr(9'h040 + 9'(i), 1'b1);
        settle_w();
        check("R11 thirteen words", 32'(almost_full_n), 1);
        wr(9'h04D, 1'b1);
        settle_w();
        check("R11 fourteen words", 32'(almost_full_n), 0);
        check("R9 not full at 14", 32'(full_n), 1);
        wr(9'h04E, 1'b1); wr(9'h04F, 1'b1);
        settle_w();
        check("R9 full at DEPTH", 32'(full_n), 0);
        wr(9'h1EE, 1'b1);  // R6: must be dropped
        for (int i = 0; i < DEPTH; i++) rd("R6 drain order", 9'h040 + 9'(i));
        settle_r();
        check("R6 extra word absent", 32'(empty_n), 0);
        @(negedge rclk); ren1_n = 0; ren2_n = 0;
        @(negedge rclk); ren1_n = 1; ren2_n = 1;
        check("R7 dout held on empty read", 32'(dout), 32'h04F);
        settle_w();
        check("R9 full released", 32'(full_n), 1);

        // R2/R4: load-control mode
        ae_ofs = AW'(7); af_ofs = AW'(7);
        do_reset(1'b0);
        @(negedge wclk); din = 9'h111; wen1_n = 0; wen2_ld = 0;
        #1 check("R4 ofs_wr in load mode", 32'(ofs_wr), 1);
        @(negedge wclk); wen1_n = 1; wen2_ld = 1;
        settle_r();
        check("R4 load-low write not stored", 32'(empty_n), 0);
        wr(9'h122, 1'b1);
        rd("R4 load mode write", 9'h122);

        // R2/R3: two-enable mode
        do_reset(1'b1);
        @(negedge wclk); din = 9'h133; wen1_n = 0; wen2_ld = 0;
        #1 check("R2 ofs_wr idle in two-enable mode", 32'(ofs_wr), 0);
        @(negedge wclk); wen1_n = 1; wen2_ld = 1;
        settle_r();
        check("R3 wen2 low blocks write", 32'(empty_n), 0);
        wr(9'h144, 1'b1);
        rd("R3 two-enable write", 9'h144);

        // R12
        oe_n = 1; #1 check("R12 q_valid off", 32'(q_valid), 0);
        oe_n = 0; #1 check("R12 q_valid on", 32'(q_valid), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule